// File: doc/BRIEF.md
# Two-Key Serviced Watchdog Timer

This block is a watchdog timer that sits on a simple 16-bit register bus. It has three registers: control at offset 0, service at offset 2 and reset cause at offset 4. Software writes the control register to set a timeout in half-second steps and to turn the watchdog on. The enable is write-once: once it is set, it stays set until power-on reset. A slow tick input, two pulses per second, drives a down-counter. The counter runs only while the watchdog is enabled and no chosen halt condition (low-power or debug) is active.

Software keeps the system alive by writing an ordered pair of key words to the service register: 0x5555 and then 0xAAAA. Only the second word of a correct pair reloads the counter. When the counter runs out, the block records a timeout cause and, if the control register allows it, pulses a system reset output for one clock cycle. A write to the control register can also request an immediate software reset, which records a cause of its own.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset, reads return 0x0000 at offsets 0, 2 and 4, and `sys_rst_o` is low.
- R2: The control register at offset 0 reads back bit 0 (hold counting in low power), bit 1 (hold counting in debug), bit 2 (enable), bit 3 (reset on expiry), bit 7 (a spare flag that is stored only) and bits 15:8 (the timeout field WT). Bits 4, 5 and 6 read as 0.
- R3: Once the enable bit (control bit 2) is 1, a control write with bit 2 at 0 leaves it at 1.
- R4: The counter is loaded with WT+1 when the enable first turns on and after each valid service. It counts down one step per tick while enabled and not held. On the (WT+1)-th counted tick it expires and reloads with WT+1. With WT=0xFF the period is 256 ticks. No tick counts while the block is disabled.
- R5: Writing 0x5555 and then 0xAAAA to offset 2 reloads the counter with the current WT+1 on the second write.
- R6: Any service write other than the expected next key returns the sequence to waiting for 0x5555 and does not reload the counter. This includes 0x5555 written twice in a row and any other word written between the two keys.
- R7: While control bit 0 is 1 and `lp_halt_i` is high, or control bit 1 is 1 and `dbg_halt_i` is high, ticks are not counted. A halt input has no effect while its control bit is 0.
- R8: On expiry, status bit 0 (timeout cause) is set. `sys_rst_o` is high for exactly the following cycle only if control bit 3 is 1.
- R9: A control write with bit 4 set drives `sys_rst_o` high for the following cycle and sets status bit 1 (software cause). Bit 4 does not stay set.
- R10: The status register at offset 4 is read-only. Writes to it are ignored, and its bits stay set until power-on reset.
- R11: With WT=0 and the watchdog enabled, a valid service loads the minimum period, so the next counted tick expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | One-cycle pulse every half second |
| lp_halt_i | input | 1 | System is in low-power mode |
| dbg_halt_i | input | 1 | System is halted by a debugger |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W (3) | Register byte offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The case that is hardest to reach from the ports is a broken key sequence, because a reload that fails shows up only in the timing of a later expiry. The stimulus places each bad sequence (a foreign word between the keys, or the first key written twice) at a point where a wrongful reload would move the next expiry by at least one tick. It then checks the tick on which the reset pulse appears. Hold behaviour is shown the same way: several held ticks are followed by exactly WT+1 counted ticks. The 256-tick maximum period is run tick by tick to check both edges of the boundary.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned WT_W   = 8;
    localparam int unsigned WT_LSB = 8;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_SECOND = 16'hAAAA;

    // Control fields as held in flops.
    typedef struct packed {
        logic [WT_W-1:0] wt;
        logic            spare;
        logic            rst_on_exp;
        logic            en;
        logic            dbg_hold;
        logic            lp_hold;
    } ctrl_t;

    typedef struct packed {
        logic sw_cause;
        logic to_cause;
    } cause_t;
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
    import wdk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              reload_o
);
    typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_e;

    typedef struct packed {
        seq_e st;
    } seq_st_t;

    seq_st_t seq_q, seq_d;

    always_comb begin
        seq_d    = seq_q;
        reload_o = 1'b0;
        if (wr_i) begin
            if (seq_q.st == SEQ_IDLE && data_i == KEY_FIRST) begin
                seq_d.st = SEQ_ARMED;
            end else if (seq_q.st == SEQ_ARMED && data_i == KEY_SECOND) begin
                seq_d.st = SEQ_IDLE;
                reload_o = 1'b1;
            end else begin
                seq_d.st = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE};
        else        seq_q <= seq_d;
    end

    // After a completed pair the sequence waits for the first key again.
    assert_seq_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> seq_q.st == SEQ_IDLE);

    // The state moves only on a service write.
    assert_seq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(seq_q.st));
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t c_q, c_d;

    always_comb begin
        c_d      = c_q;
        expire_o = 1'b0;
        if (load_i) begin
            c_d.cnt = load_val_i;
        end else if (run_i && tick_i) begin
            if (c_q.cnt == ONE) begin
                expire_o = 1'b1;
                c_d.cnt  = load_val_i;
            end else begin
                c_d.cnt = c_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !load_i && c_q.cnt > ONE) |=> c_q.cnt == $past(c_q.cnt) - ONE);

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(c_q.cnt));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdk_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              lp_halt_i,
    input  logic              dbg_halt_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              sys_rst_o
);
    localparam int unsigned CNT_W = WT_W + 1;
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_SVC  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);

    typedef struct packed {
        ctrl_t  ctrl;
        cause_t cause;
        logic   rst;
    } top_st_t;

    top_st_t s_q, s_d;

    logic             ctrl_wr, svc_wr, svc_reload, enabling;
    logic             held, run, load, expire;
    logic [CNT_W-1:0] load_val;

    assign ctrl_wr = bus_wr_i && (bus_addr_i == OFS_CTRL);
    assign svc_wr  = bus_wr_i && (bus_addr_i == OFS_SVC);

    wdk_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (svc_wr),
        .data_i   (bus_wdata_i),
        .reload_o (svc_reload)
    );

    always_comb begin
        enabling = ctrl_wr && bus_wdata_i[2] && !s_q.ctrl.en;
        held     = (lp_halt_i && s_q.ctrl.lp_hold) || (dbg_halt_i && s_q.ctrl.dbg_hold);
        run      = s_q.ctrl.en && !held;
        load     = enabling || svc_reload;
        if (enabling) load_val = CNT_W'(bus_wdata_i[WT_LSB +: WT_W]) + CNT_W'(1);
        else          load_val = CNT_W'(s_q.ctrl.wt) + CNT_W'(1);
    end

    wdk_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .run_i      (run),
        .tick_i     (tick_i),
        .expire_o   (expire)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rst = 1'b0;
        if (ctrl_wr) begin
            s_d.ctrl.lp_hold    = bus_wdata_i[0];
            s_d.ctrl.dbg_hold   = bus_wdata_i[1];
            s_d.ctrl.en         = s_q.ctrl.en || bus_wdata_i[2];
            s_d.ctrl.rst_on_exp = bus_wdata_i[3];
            s_d.ctrl.spare      = bus_wdata_i[7];
            s_d.ctrl.wt         = bus_wdata_i[WT_LSB +: WT_W];
            if (bus_wdata_i[4]) begin
                s_d.rst            = 1'b1;
                s_d.cause.sw_cause = 1'b1;
            end
        end
        if (expire) begin
            s_d.cause.to_cause = 1'b1;
            if (s_q.ctrl.rst_on_exp) s_d.rst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (bus_addr_i)
            OFS_CTRL: bus_rdata_o = {s_q.ctrl.wt, s_q.ctrl.spare, 3'b000, s_q.ctrl.rst_on_exp,
                                     s_q.ctrl.en, s_q.ctrl.dbg_hold, s_q.ctrl.lp_hold};
            OFS_STAT: bus_rdata_o = {{(DATA_W-2){1'b0}}, s_q.cause.sw_cause, s_q.cause.to_cause};
            default:  bus_rdata_o = '0;
        endcase
    end

    assign sys_rst_o = s_q.rst;

    assert_en_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl.en |=> s_q.ctrl.en);

    assert_to_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cause.to_cause |=> s_q.cause.to_cause);

    assert_sw_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cause.sw_cause |=> s_q.cause.sw_cause);

    assert_rst_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (s_q.cause.to_cause || s_q.cause.sw_cause));
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, lp_halt_i = 1'b0, dbg_halt_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic        sys_rst_o;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    keyed_wdog u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .lp_halt_i(lp_halt_i),
        .dbg_halt_i(dbg_halt_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .sys_rst_o(sys_rst_o)
    );

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2;
    localparam int NV = 44;
    // {kind, requirement number, offset, write data, expected (read data or reset pulse)}
    localparam logic [40:0] VEC [NV] = '{
        {K_RD, 4'd1,  3'd0, 16'h0000, 16'h0000},  // R1
        {K_RD, 4'd1,  3'd4, 16'h0000, 16'h0000},  // R1
        {K_TK, 4'd4,  3'd0, 16'h0000, 16'h0000},  // R4 disabled
        {K_WR, 4'd2,  3'd0, 16'h020C, 16'h0000},  // WT=2, enable, reset on expiry
        {K_RD, 4'd2,  3'd0, 16'h0000, 16'h020C},  // R2
        {K_TK, 4'd4,  3'd0, 16'h0000, 16'h0000},
        {K_TK, 4'd4,  3'd0, 16'h0000, 16'h0000},
        {K_TK, 4'd4,  3'd0, 16'h0000, 16'h0001},  // R4 third tick
        {K_RD, 4'd8,  3'd4, 16'h0000, 16'h0001},  // R8 timeout cause
        {K_TK, 4'd4,  3'd0, 16'h0000, 16'h0000},
        {K_WR, 4'd5,  3'd2, 16'h5555, 16'h0000},
        {K_WR, 4'd5,  3'd2, 16'hAAAA, 16'h0000},  // R5 reload to 3
        {K_TK, 4'd5,  3'd0, 16'h0000, 16'h0000},
        {K_TK, 4'd5,  3'd0, 16'h0000, 16'h0000},
        {K_TK, 4'd5,  3'd0, 16'h0000, 16'h0001},
        {K_TK, 4'd6,  3'd0, 16'h0000, 16'h0000},
        {K_WR, 4'd6,  3'd2, 16'h5555, 16'h0000},
        {K_WR, 4'd6,  3'd2, 16'h1234, 16'h0000},
        {K_WR, 4'd6,  3'd2, 16'hAAAA, 16'h0000},  // R6 broken pair
        {K_TK, 4'd6,  3'd0, 16'h0000, 16'h0000},
        {K_TK, 4'd6,  3'd0, 16'h0000, 16'h0001},
        {K_TK, 4'd6,  3'd0, 16'h0000, 16'h0000},
        {K_WR, 4'd6,  3'd2, 16'h5555, 16'h0000},
        {K_WR, 4'd6,  3'd2, 16'h5555, 16'h0000},
        {K_WR, 4'd6,  3'd2, 16'hAAAA, 16'h0000},  // R6 repeated first key
        {K_TK, 4'd6,  3'd0, 16'h0000, 16'h0000},
        {K_TK, 4'd6,  3'd0, 16'h0000, 16'h0001},
        {K_WR, 4'd2,  3'd0, 16'h02EC, 16'h0000},
        {K_RD, 4'd2,  3'd0, 16'h0000, 16'h028C},  // R2 bits 5,6 read 0
        {K_WR, 4'd3,  3'd0, 16'h0000, 16'h0000},
        {K_RD, 4'd3,  3'd0, 16'h0000, 16'h0004},  // R3 enable stays
        {K_TK, 4'd8,  3'd0, 16'h0000, 16'h0000},
        {K_TK, 4'd8,  3'd0, 16'h0000, 16'h0000},
        {K_TK, 4'd8,  3'd0, 16'h0000, 16'h0000},  // R8 expiry, no pulse
        {K_TK, 4'd8,  3'd0, 16'h0000, 16'h0000},
        {K_WR, 4'd10, 3'd4, 16'hFFFF, 16'h0000},
        {K_RD, 4'd10, 3'd4, 16'h0000, 16'h0001},  // R10 write ignored
        {K_WR, 4'd11, 3'd0, 16'h0008, 16'h0000},
        {K_WR, 4'd11, 3'd2, 16'h5555, 16'h0000},
        {K_WR, 4'd11, 3'd2, 16'hAAAA, 16'h0000},
        {K_TK, 4'd11, 3'd0, 16'h0000, 16'h0001},  // R11 one tick
        {K_WR, 4'd9,  3'd0, 16'h0018, 16'h0001},  // R9 software reset
        {K_RD, 4'd9,  3'd4, 16'h0000, 16'h0003},
        {K_RD, 4'd9,  3'd0, 16'h0000, 16'h000C}
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [15:0] d, output logic seen);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
        seen = sys_rst_o;
    endtask

    task automatic do_tick(output logic seen);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        seen = sys_rst_o;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr_i = a;
        #1 v = bus_rdata_o;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic        s;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        chk(1, {15'd0, sys_rst_o}, 16'h0000);  // R1 during reset
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [3:0]  r;
            logic [2:0]  a;
            logic [15:0] d, e;
            {k, r, a, d, e} = VEC[i];
            case (k)
                K_WR: begin do_wr(a, d, s); chk(int'(r), {15'd0, s}, e); end
                K_RD: begin do_rd(a, v); chk(int'(r), v, e); end
                default: begin do_tick(s); chk(int'(r), {15'd0, s}, e); end
            endcase
        end

        // R1/R10: power-on reset clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_rd(3'd0, v); chk(1, v, 16'h0000);
        do_rd(3'd4, v); chk(10, v, 16'h0000);
        do_rd(3'd2, v); chk(1, v, 16'h0000);

        // R7: holds, WT=3 -> 4 counted ticks
        do_wr(3'd0, 16'h030F, s); chk(7, {15'd0, s}, 16'h0000);
        lp_halt_i = 1'b1;
        for (int i = 0; i < 5; i++) begin do_tick(s); chk(7, {15'd0, s}, 16'h0000); end
        lp_halt_i = 1'b0; dbg_halt_i = 1'b1;
        for (int i = 0; i < 5; i++) begin do_tick(s); chk(7, {15'd0, s}, 16'h0000); end
        dbg_halt_i = 1'b0;
        for (int i = 0; i < 3; i++) begin do_tick(s); chk(7, {15'd0, s}, 16'h0000); end
        do_tick(s); chk(7, {15'd0, s}, 16'h0001);
        // R7: halt inputs ignored with hold bits clear
        do_wr(3'd0, 16'h0308, s);
        lp_halt_i = 1'b1; dbg_halt_i = 1'b1;
        for (int i = 0; i < 3; i++) begin do_tick(s); chk(7, {15'd0, s}, 16'h0000); end
        do_tick(s); chk(7, {15'd0, s}, 16'h0001);
        lp_halt_i = 1'b0; dbg_halt_i = 1'b0;

        // R4: maximum period of 256 ticks
        do_wr(3'd0, 16'hFF08, s);
        do_wr(3'd2, 16'h5555, s);
        do_wr(3'd2, 16'hAAAA, s);
        for (int i = 0; i < 255; i++) begin
            do_tick(s);
            chk(4, {15'd0, s}, 16'h0000);
        end
        do_tick(s); chk(4, {15'd0, s}, 16'h0001);
        do_rd(3'd0, v); chk(2, v, 16'hFF0C);

        finish_run();
    end
endmodule